// File: doc/BRIEF.md
# Tagged Address Translation Cache

This block is a small fully associative cache of page translations. A lookup presents a virtual page number, an in-page offset, the access kind (load or store) and the privilege (user or kernel). The block matches these against its stored entries using both the page number and the identity of the running process. One cycle later it returns a registered response: hit or miss, the physical address, and a fault flag when the mapping is invalid or the access is not allowed.

Entries are written through a fill port, either by an external table walker or by software. A fill reuses an entry that already holds the same page and process, then the lowest free slot, and only then the slot chosen by a tree pseudo-LRU. A single mapping can be removed when its table entry changes, and the whole cache can be emptied at once for systems that switch processes without tags. On a context switch the system only needs to change the current-process input.

Top module: `tagged_tlb`

## Requirements
- R1: A lookup request sampled at a clock edge produces `rsp_valid` high after that edge, with exactly one of `rsp_hit` and `rsp_miss` set. A clean hit returns `rsp_paddr = {ppn, offset}`. Without a request, all response outputs are 0.
- R2: An entry matches only when both its page number equals `lk_vpn` and its process tag equals `cur_tag`. The same page under another tag misses.
- R3: A match on an entry whose mapping-valid bit is 0 sets `rsp_hit` and `rsp_page_fault`, with `rsp_paddr` equal to 0.
- R4: Rights use a 2-bit code: 00 means no access, 01 means read only, and 10 or 11 means read and write. User lookups use the user code and kernel lookups use the kernel code. A load needs a nonzero code and a store needs bit 1 set. A violation on a valid entry sets `rsp_hit` and `rsp_prot_fault`, with `rsp_paddr` equal to 0.
- R5: On a clean hit, `rsp_ref` and `rsp_mod` report the entry's referenced and modified bits as they stood before this access. A clean hit sets the referenced bit, and a clean store hit also sets the modified bit. A fill clears both bits.
- R6: A fill overwrites an entry holding the same page and tag. Otherwise it takes the lowest-index empty entry. If no entry is empty, it takes the pseudo-LRU victim. At most one entry ever matches a key.
- R7: Replacement uses a 7-node tree for 8 entries, and both clean hits and fills touch the tree. After fills into entries 0 to 7 in order followed by a hit on entry 0, the next fill replaces entry 4.
- R8: An invalidate removes only the entry matching both `inv_vpn` and `inv_tag`.
- R9: `flush_all` empties every entry. A fill in the same cycle is dropped.
- R10: A fill and a lookup for the same page and current tag in the same cycle return a hit carrying the filled translation.
- R11: After reset, the cache is empty and all response outputs are 0.
- R12: A clean hit reports the entry's cacheable bit on `rsp_cacheable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_tag | input | 8 | Tag of the running process |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_off | input | 12 | Lookup byte offset within the page |
| lk_write | input | 1 | 1 for a store, 0 for a load |
| lk_user | input | 1 | 1 for a user access, 0 for a kernel access |
| fill_en | input | 1 | Write one translation |
| fill_vpn | input | 20 | Fill virtual page number |
| fill_tag | input | 8 | Fill process tag |
| fill_ppn | input | 20 | Fill physical page number |
| fill_valid | input | 1 | Mapping-valid bit of the fill |
| fill_kperm | input | 2 | Kernel rights code |
| fill_uperm | input | 2 | User rights code |
| fill_cacheable | input | 1 | Cacheable bit of the fill |
| inv_en | input | 1 | Invalidate one entry |
| inv_vpn | input | 20 | Page to invalidate |
| inv_tag | input | 8 | Tag to invalidate |
| flush_all | input | 1 | Empty the whole cache |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | An entry matched |
| rsp_miss | output | 1 | No entry matched |
| rsp_page_fault | output | 1 | Matched entry is not a valid mapping |
| rsp_prot_fault | output | 1 | Access not allowed by the rights |
| rsp_paddr | output | 32 | Physical address on a clean hit |
| rsp_cacheable | output | 1 | Cacheable bit on a clean hit |
| rsp_ref | output | 1 | Referenced bit before this access |
| rsp_mod | output | 1 | Modified bit before this access |

## Verification
Three pairs of functions can fall in the same cycle: a fill with a lookup of the same page, a fill with a full flush, and an invalidate with entries it must not touch. The bench drives each pair at the same falling edge. It then judges the outcome at the response ports. The same-cycle lookup must report the new translation. After a flush, both the dropped fill and the old pages must miss. A wrongly tagged invalidate must leave its page hitting. Replacement order is judged by which page disappears after a full cache and a known touch sequence.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    RIGHTS_NONE = 2'b00,
    RIGHTS_RD   = 2'b01,
    RIGHTS_RW   = 2'b10,
    RIGHTS_RWX  = 2'b11
  } rights_e;

  function automatic logic rights_allow(input logic [1:0] code, input logic is_store);
    if (is_store) return code[1];
    return code != RIGHTS_NONE;
  endfunction
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int TAG_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]            used,
  input  logic [ENTRIES-1:0][VPN_W-1:0] vpns,
  input  logic [ENTRIES-1:0][TAG_W-1:0] tags,
  input  logic [VPN_W-1:0]              key_vpn,
  input  logic [TAG_W-1:0]              key_tag,
  output logic [ENTRIES-1:0]            hit_vec,
  output logic                          any_hit,
  output logic [IDX_W-1:0]              hit_idx
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = used[g] && (vpns[g] == key_vpn) && (tags[g] == key_tag);
  end

  assign any_hit = |hit_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec[i]) hit_idx = hit_idx | IDX_W'(i);
  end
endmodule

// File: rtl/tlb_plru.sv
module tlb_plru #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             a_en,
  input  logic [IDX_W-1:0] a_idx,
  input  logic             b_en,
  input  logic [IDX_W-1:0] b_idx,
  output logic [IDX_W-1:0] victim
);
  logic [ENTRIES-2:0] tree, tree_nx;
  logic               last_en;
  logic [IDX_W-1:0]   last_idx;

  function automatic logic [ENTRIES-2:0] touch(input logic [ENTRIES-2:0] t,
                                               input logic [IDX_W-1:0] e);
    int n;
    n = ENTRIES + int'(e);
    for (int l = 0; l < IDX_W; l++) begin
      t[(n >> 1) - 1] = ~n[0];
      n = n >> 1;
    end
    return t;
  endfunction

  always_comb begin
    tree_nx = tree;
    if (a_en) tree_nx = touch(tree_nx, a_idx);
    if (b_en) tree_nx = touch(tree_nx, b_idx);
  end

  always_comb begin
    int n;
    n = 1;
    for (int l = 0; l < IDX_W; l++) n = 2 * n + int'(tree[n-1]);
    victim = IDX_W'(n - ENTRIES);
  end

  always_ff @(posedge clk) begin
    if (rst) tree <= '0;
    else     tree <= tree_nx;
  end

  assign last_en  = a_en || b_en;
  assign last_idx = b_en ? b_idx : a_idx;

  // R7
  victim_not_recent_chk: assert property (@(posedge clk) disable iff (rst)
    last_en |=> victim != $past(last_idx));
endmodule

// File: rtl/tagged_tlb.sv
module tagged_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int TAG_W   = 8,
  parameter int OFF_W   = 12,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int PA_W   = PPN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TAG_W-1:0] cur_tag,
  input  logic             lk_req,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [OFF_W-1:0] lk_off,
  input  logic             lk_write,
  input  logic             lk_user,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_valid,
  input  logic [1:0]       fill_kperm,
  input  logic [1:0]       fill_uperm,
  input  logic             fill_cacheable,
  input  logic             inv_en,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic [TAG_W-1:0] inv_tag,
  input  logic             flush_all,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic             rsp_page_fault,
  output logic             rsp_prot_fault,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_cacheable,
  output logic             rsp_ref,
  output logic             rsp_mod
);
  // Entry state: occupancy and usage bits are reset, payload fields are not.
  logic [ENTRIES-1:0]            used, refb, modb;
  logic [ENTRIES-1:0][VPN_W-1:0] e_vpn;
  logic [ENTRIES-1:0][TAG_W-1:0] e_tag;
  logic [ENTRIES-1:0][PPN_W-1:0] e_ppn;
  logic [ENTRIES-1:0][1:0]       e_kp, e_up;
  logic [ENTRIES-1:0]            e_val, e_cach;

  logic [ENTRIES-1:0] l_vec, f_vec, i_vec;
  logic               l_any, f_any, i_any;
  logic [IDX_W-1:0]   l_idx, f_idx, i_idx, victim, fill_idx;

  tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .TAG_W(TAG_W)) u_cam_lk (
    .used(used), .vpns(e_vpn), .tags(e_tag), .key_vpn(lk_vpn), .key_tag(cur_tag),
    .hit_vec(l_vec), .any_hit(l_any), .hit_idx(l_idx));
  tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .TAG_W(TAG_W)) u_cam_fill (
    .used(used), .vpns(e_vpn), .tags(e_tag), .key_vpn(fill_vpn), .key_tag(fill_tag),
    .hit_vec(f_vec), .any_hit(f_any), .hit_idx(f_idx));
  tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .TAG_W(TAG_W)) u_cam_inv (
    .used(used), .vpns(e_vpn), .tags(e_tag), .key_vpn(inv_vpn), .key_tag(inv_tag),
    .hit_vec(i_vec), .any_hit(i_any), .hit_idx(i_idx));

  // Fill placement: same key, then lowest empty, then tree victim.
  always_comb begin
    fill_idx = victim;
    if (f_any) fill_idx = f_idx;
    else if (!(&used)) begin
      for (int i = ENTRIES - 1; i >= 0; i--)
        if (!used[i]) fill_idx = IDX_W'(i);
    end
  end

  logic fill_go, bypass;
  assign fill_go = fill_en && !flush_all;
  assign bypass  = fill_go && (fill_vpn == lk_vpn) && (fill_tag == cur_tag);

  // Selected entry view for the lookup.
  logic             s_hit, s_val, s_cach, s_ref, s_mod;
  logic [1:0]       s_kp, s_up, s_rights;
  logic [PPN_W-1:0] s_ppn;
  logic             s_pf, s_prot, s_ok, hit_touch;

  always_comb begin
    s_hit = 1'b0; s_val = 1'b0; s_cach = 1'b0; s_ref = 1'b0; s_mod = 1'b0;
    s_kp = '0; s_up = '0; s_ppn = '0;
    if (bypass) begin
      s_hit = 1'b1; s_val = fill_valid; s_cach = fill_cacheable;
      s_kp = fill_kperm; s_up = fill_uperm; s_ppn = fill_ppn;
    end else if (l_any) begin
      s_hit = 1'b1; s_val = e_val[l_idx]; s_cach = e_cach[l_idx];
      s_ref = refb[l_idx]; s_mod = modb[l_idx];
      s_kp = e_kp[l_idx]; s_up = e_up[l_idx]; s_ppn = e_ppn[l_idx];
    end
    s_rights = lk_user ? s_up : s_kp;
    s_pf     = s_hit && !s_val;
    s_prot   = s_hit && s_val && !rights_allow(s_rights, lk_write);
    s_ok     = s_hit && s_val && !s_prot;
  end

  assign hit_touch = lk_req && s_ok && !bypass;

  tlb_plru #(.ENTRIES(ENTRIES)) u_plru (
    .clk(clk), .rst(rst),
    .a_en(hit_touch), .a_idx(l_idx),
    .b_en(fill_go), .b_idx(fill_idx),
    .victim(victim));

  // Payload storage: no reset, one write port.
  always_ff @(posedge clk) begin
    if (fill_go) begin
      e_vpn[fill_idx]  <= fill_vpn;
      e_tag[fill_idx]  <= fill_tag;
      e_ppn[fill_idx]  <= fill_ppn;
      e_kp[fill_idx]   <= fill_kperm;
      e_up[fill_idx]   <= fill_uperm;
      e_val[fill_idx]  <= fill_valid;
      e_cach[fill_idx] <= fill_cacheable;
    end
  end

  // Occupancy and usage bits. Later statements take priority.
  always_ff @(posedge clk) begin
    if (rst) begin
      used <= '0; refb <= '0; modb <= '0;
    end else begin
      if (hit_touch) begin
        refb[l_idx] <= 1'b1;
        if (lk_write) modb[l_idx] <= 1'b1;
      end
      if (inv_en && i_any) used[i_idx] <= 1'b0;
      if (fill_go) begin
        used[fill_idx] <= 1'b1;
        refb[fill_idx] <= 1'b0;
        modb[fill_idx] <= 1'b0;
      end
      if (flush_all) used <= '0;
    end
  end

  // Registered response.
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0; rsp_hit <= 1'b0; rsp_miss <= 1'b0;
      rsp_page_fault <= 1'b0; rsp_prot_fault <= 1'b0; rsp_paddr <= '0;
      rsp_cacheable <= 1'b0; rsp_ref <= 1'b0; rsp_mod <= 1'b0;
    end else begin
      rsp_valid      <= lk_req;
      rsp_hit        <= lk_req && s_hit;
      rsp_miss       <= lk_req && !s_hit;
      rsp_page_fault <= lk_req && s_pf;
      rsp_prot_fault <= lk_req && s_prot;
      rsp_paddr      <= (lk_req && s_ok) ? {s_ppn, lk_off} : '0;
      rsp_cacheable  <= lk_req && s_ok && s_cach;
      rsp_ref        <= lk_req && s_ok && s_ref;
      rsp_mod        <= lk_req && s_ok && s_mod;
    end
  end

  // R1
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> rsp_valid && (rsp_hit != rsp_miss));
  // R1
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> !rsp_valid && !rsp_hit && !rsp_miss && rsp_paddr == '0);
  // R3
  fault_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_page_fault || rsp_prot_fault) |-> rsp_hit && !(rsp_page_fault && rsp_prot_fault)
      && rsp_paddr == '0);
  // R6
  single_match_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(l_vec) && $onehot0(f_vec));
  // R9
  flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
    flush_all |=> used == '0);
endmodule

// File: tb/tagged_tlb_tb.sv
module tagged_tlb_tb;
  localparam int VPN_W = 20, PPN_W = 20, TAG_W = 8, OFF_W = 12;
  localparam logic [OFF_W-1:0] OFF = 12'h5A5;

  logic clk = 1'b0, rst = 1'b1;
  logic [TAG_W-1:0] cur_tag = 8'd5;
  logic lk_req = 0, lk_write = 0, lk_user = 0;
  logic [VPN_W-1:0] lk_vpn = '0;
  logic [OFF_W-1:0] lk_off = OFF;
  logic fill_en = 0, fill_valid = 0, fill_cacheable = 0;
  logic [VPN_W-1:0] fill_vpn = '0;
  logic [TAG_W-1:0] fill_tag = '0;
  logic [PPN_W-1:0] fill_ppn = '0;
  logic [1:0] fill_kperm = '0, fill_uperm = '0;
  logic inv_en = 0, flush_all = 0;
  logic [VPN_W-1:0] inv_vpn = '0;
  logic [TAG_W-1:0] inv_tag = '0;
  logic rsp_valid, rsp_hit, rsp_miss, rsp_page_fault, rsp_prot_fault;
  logic rsp_cacheable, rsp_ref, rsp_mod;
  logic [PPN_W+OFF_W-1:0] rsp_paddr;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tagged_tlb u_dut (.*);

  // {vpn20, store, user, hit, page_fault, prot_fault, ppn20}
  localparam logic [44:0] VEC [10] = '{
    {20'h00010, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 20'hAAA10},
    {20'h00010, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 20'hAAA10},
    {20'h00020, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 20'hBBB20},
    {20'h00020, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 20'h00000},
    {20'h00020, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 20'hBBB20},
    {20'h00030, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 20'h00000},
    {20'h00030, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 20'hCCC30},
    {20'h00030, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 20'h00000},
    {20'h00040, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 20'h00000},
    {20'h00050, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 20'h00000}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn, input logic [7:0] tag,
                      input logic val, input logic [1:0] kp, input logic [1:0] up,
                      input logic cach);
    fill_en = 1; fill_vpn = vpn; fill_ppn = ppn; fill_tag = tag; fill_valid = val;
    fill_kperm = kp; fill_uperm = up; fill_cacheable = cach;
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic look(input logic [19:0] vpn, input logic wr, input logic usr);
    lk_req = 1; lk_vpn = vpn; lk_write = wr; lk_user = usr;
    @(negedge clk);
    lk_req = 0;
  endtask

  task automatic expect_hit(input string req, input logic [19:0] vpn, input logic [19:0] ppn);
    look(vpn, 1'b0, 1'b0);
    chk(req, rsp_hit, 1'b1);
    chk(req, rsp_paddr, {ppn, OFF});
  endtask

  task automatic expect_miss(input string req, input logic [19:0] vpn);
    look(vpn, 1'b0, 1'b0);
    chk(req, {rsp_valid, rsp_miss, rsp_hit}, 3'b110);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R11 reset state
    chk("R11", {rsp_valid, rsp_hit, rsp_miss, rsp_page_fault, rsp_prot_fault, rsp_paddr}, '0);
    expect_miss("R11", 20'h00123);
    @(negedge clk);
    chk("R1", {rsp_valid, rsp_hit, rsp_miss}, 3'b000);

    fill(20'h00010, 20'hAAA10, 8'd5, 1, 2'b10, 2'b10, 1);
    fill(20'h00020, 20'hBBB20, 8'd5, 1, 2'b11, 2'b01, 0);
    fill(20'h00030, 20'hCCC30, 8'd5, 1, 2'b01, 2'b00, 0);
    fill(20'h00040, 20'hDDD40, 8'd5, 0, 2'b11, 2'b11, 0);
    fill(20'h00010, 20'h99910, 8'd9, 1, 2'b10, 2'b10, 0);

    // R1 R3 R4 table walk
    for (int i = 0; i < 10; i++) begin
      logic [44:0] v;
      logic ok;
      v = VEC[i];
      ok = v[22] && !v[21] && !v[20];
      look(v[44:25], v[24], v[23]);
      chk("R1", {rsp_valid, rsp_hit, rsp_miss}, {1'b1, v[22], !v[22]});
      chk("R3", rsp_page_fault, v[21]);
      chk("R4", rsp_prot_fault, v[20]);
      chk("R1", rsp_paddr, ok ? {v[19:0], OFF} : 32'h0);
    end

    // R2 tag selects the mapping
    cur_tag = 8'd9; expect_hit("R2", 20'h00010, 20'h99910);
    cur_tag = 8'd7; expect_miss("R2", 20'h00010);
    cur_tag = 8'd5;

    // R12 cacheable reporting
    look(20'h00010, 0, 0); chk("R12", rsp_cacheable, 1'b1);
    look(20'h00020, 0, 0); chk("R12", rsp_cacheable, 1'b0);

    // R5 referenced / modified
    fill(20'h00060, 20'h66660, 8'd5, 1, 2'b10, 2'b10, 0);
    look(20'h00060, 0, 1); chk("R5", {rsp_ref, rsp_mod}, 2'b00);
    look(20'h00060, 1, 1); chk("R5", {rsp_ref, rsp_mod}, 2'b10);
    look(20'h00060, 0, 1); chk("R5", {rsp_ref, rsp_mod}, 2'b11);
    fill(20'h00060, 20'h66661, 8'd5, 1, 2'b10, 2'b10, 0);
    look(20'h00060, 0, 1); chk("R5", {rsp_ref, rsp_mod}, 2'b00);

    // R6 overwrite of existing key
    fill(20'h00010, 20'h12345, 8'd5, 1, 2'b10, 2'b10, 0);
    expect_hit("R6", 20'h00010, 20'h12345);

    // R9 flush
    flush_all = 1; @(negedge clk); flush_all = 0;
    expect_miss("R9", 20'h00020);

    // R7 pseudo-LRU victim
    for (int i = 0; i < 8; i++) fill(20'h00100 + i, 20'h80000 + i, 8'd5, 1, 2'b10, 2'b10, 0);
    expect_hit("R7", 20'h00100, 20'h80000);
    fill(20'h00200, 20'h90200, 8'd5, 1, 2'b10, 2'b10, 0);
    expect_miss("R7", 20'h00104);
    expect_hit("R7", 20'h00100, 20'h80000);
    expect_hit("R7", 20'h00105, 20'h80005);
    expect_hit("R7", 20'h00200, 20'h90200);

    // R8 invalidate by page and tag
    inv_en = 1; inv_vpn = 20'h00101; inv_tag = 8'd9; @(negedge clk); inv_en = 0;
    expect_hit("R8", 20'h00101, 20'h80001);
    inv_en = 1; inv_vpn = 20'h00102; inv_tag = 8'd5; @(negedge clk); inv_en = 0;
    expect_miss("R8", 20'h00102);

    // R6 lowest empty slot before victim
    fill(20'h00300, 20'h90300, 8'd5, 1, 2'b10, 2'b10, 0);
    expect_hit("R6", 20'h00300, 20'h90300);
    expect_hit("R6", 20'h00100, 20'h80000);
    expect_hit("R6", 20'h00101, 20'h80001);
    expect_hit("R6", 20'h00103, 20'h80003);
    expect_hit("R6", 20'h00105, 20'h80005);
    expect_hit("R6", 20'h00106, 20'h80006);
    expect_hit("R6", 20'h00107, 20'h80007);
    expect_hit("R6", 20'h00200, 20'h90200);

    // R9 flush beats fill in the same cycle
    flush_all = 1;
    fill(20'h00400, 20'h90400, 8'd5, 1, 2'b10, 2'b10, 0);
    flush_all = 0;
    expect_miss("R9", 20'h00400);
    expect_miss("R9", 20'h00100);

    // R10 fill and lookup together
    lk_req = 1; lk_vpn = 20'h00500; lk_write = 0; lk_user = 0;
    fill(20'h00500, 20'h55500, 8'd5, 1, 2'b10, 2'b10, 0);
    lk_req = 0;
    chk("R10", {rsp_hit, rsp_page_fault, rsp_prot_fault}, 3'b100);
    chk("R10", rsp_paddr, {20'h55500, OFF});
    expect_hit("R10", 20'h00500, 20'h55500);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule